// File: doc/BRIEF.md
# Sequential Combination Lock Controller

The block opens a door once a three-value secret code has been keyed in, one value at a time. Each value is a 4-bit word on a shared value bus. A single-cycle strobe marks that the word is a new entry. The secret code sits in three code registers. Each register is written from the same value bus, under its own load strobe. A one-hot select routes one register to an equality comparator. A small controller walks through the three entries.

Any wrong entry sends the controller to an error state, and it stays there. Three correct entries in a row reach the open state, and it also stays there. Only a synchronous reset leaves either state. The state word is also the output: its low bits are the comparator select, its top bit is the door-open signal, and the error state is all zeros. No separate output decoding is needed.

Top module: `combo_lock`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts `lock_state` to 4'b0001 (expecting entry 1), with `door_open` low. It does this from any state.
- R2: When `new_val` is low, `lock_state` keeps its value across the clock edge.
- R3: In a digit state, an edge with `new_val` high and `code_match` high moves the state one step: 0001 to 0010 to 0100 to 1000 (open).
- R4: In a digit state, an edge with `new_val` high and `code_match` low moves the state to 4'b0000 (error).
- R5: Once the state is open (1000) or error (0000), strobes and values leave it unchanged until the next reset.
- R6: `door_open` is high exactly when `lock_state` is 1000. Bits 2:0 of `lock_state` form the one-hot comparator select: bit 0 selects code register 1, bit 1 selects register 2, and bit 2 selects register 3.
- R7: `code_match` is combinational. It is high exactly when the selected code register equals `value_in`. It is low in the open and error states, because those states select no register.
- R8: A rising edge with `load_en[i]` high writes `value_in` into code register i+1. Loading never changes `lock_state`.
- R9: When a load and a strobe fall on the same edge, the comparison uses the register contents from before that edge. The loaded value counts only from the next cycle on.
- R10: Reset clears all three code registers to 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| value_in | input | 4 | Entered value, also the load data for the code registers |
| new_val | input | 1 | Single-cycle strobe that qualifies `value_in` as a new entry |
| load_en | input | 3 | Per-register load strobes; bit i writes code register i+1 |
| lock_state | output | 4 | Controller state: bit 3 is open, bits 2:0 are the one-hot select |
| door_open | output | 1 | High while the lock is open |
| code_match | output | 1 | Selected code register equals `value_in` |

## Verification
Writing a code register and checking an entry against that same register can happen on one clock edge. The bench raises `new_val` together with a load strobe. In one case it loads the register being compared with a different value. The state must follow the old contents, which gives an error. In the other case it loads the next register while the current entry matches. The following entry is then judged against the freshly loaded word.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 3;
  localparam int ST_W       = NUM_DIGITS + 1;

  // first digit state: lowest select bit
  function automatic logic [ST_W-1:0] st_first();
    return {{(ST_W-1){1'b0}}, 1'b1};
  endfunction

  // open state: top bit alone
  function automatic logic [ST_W-1:0] st_open();
    return {1'b1, {(ST_W-1){1'b0}}};
  endfunction

  // a digit state has no open bit and exactly one select bit
  function automatic logic is_digit(input logic [ST_W-1:0] st);
    return !st[ST_W-1] && ($countones(st[ST_W-2:0]) == 1);
  endfunction

  // next state of the controller
  function automatic logic [ST_W-1:0] step(input logic [ST_W-1:0] st,
                                           input logic strobe,
                                           input logic eq);
    if (st == st_open() || st == '0) return st;
    if (!is_digit(st)) return '0;
    if (!strobe) return st;
    return eq ? (st << 1) : '0;
  endfunction
endpackage

// File: rtl/lock_code_bank.sv
module lock_code_bank #(
  parameter int DW = 4,
  parameter int ND = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ND-1:0]   load_en,
  input  logic [DW-1:0]   value_in,
  output logic [ND*DW-1:0] codes_flat
);
  for (genvar i = 0; i < ND; i++) begin : g_reg
    logic [DW-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)             code_q <= '0;
      else if (load_en[i]) code_q <= value_in;
    end
    assign codes_flat[i*DW +: DW] = code_q;
  end
endmodule

// File: rtl/lock_compare.sv
module lock_compare #(
  parameter int DW = 4,
  parameter int ND = 3
) (
  input  logic [ND*DW-1:0] codes_flat,
  input  logic [ND-1:0]    sel,
  input  logic [DW-1:0]    value_in,
  output logic             match
);
  logic [DW-1:0] picked;
  logic          any_sel;

  always_comb begin
    picked  = '0;
    any_sel = |sel;
    for (int i = 0; i < ND; i++) begin
      picked = picked | (codes_flat[i*DW +: DW] & {DW{sel[i]}});
    end
    match = any_sel && (picked == value_in);
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import combo_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            new_val,
  input  logic            match,
  output logic [ST_W-1:0] state
);
  logic [ST_W-1:0] state_d;

  always_comb state_d = step(state, new_val, match);

  always_ff @(posedge clk) begin
    if (rst) state <= st_first();
    else     state <= state_d;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIGIT_W-1:0]    value_in,
  input  logic                  new_val,
  input  logic [NUM_DIGITS-1:0] load_en,
  output logic [ST_W-1:0]       lock_state,
  output logic                  door_open,
  output logic                  code_match
);
  logic [NUM_DIGITS*DIGIT_W-1:0] codes_flat;
  logic [NUM_DIGITS-1:0]         digit_sel;

  lock_code_bank #(.DW(DIGIT_W), .ND(NUM_DIGITS)) u_bank (
    .clk(clk), .rst(rst), .load_en(load_en), .value_in(value_in),
    .codes_flat(codes_flat)
  );

  lock_compare #(.DW(DIGIT_W), .ND(NUM_DIGITS)) u_cmp (
    .codes_flat(codes_flat), .sel(digit_sel), .value_in(value_in),
    .match(code_match)
  );

  lock_fsm u_fsm (
    .clk(clk), .rst(rst), .new_val(new_val), .match(code_match),
    .state(lock_state)
  );

  assign digit_sel = lock_state[NUM_DIGITS-1:0];
  assign door_open = lock_state[ST_W-1];
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import combo_lock_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            new_val,
  input logic [NUM_DIGITS-1:0] load_en,
  input logic [ST_W-1:0] lock_state,
  input logic            door_open,
  input logic            code_match
);
  a_r1_reset_first: assert property (@(posedge clk)
    rst |=> lock_state == st_first());

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!new_val && is_digit(lock_state)) |=> $stable(lock_state));

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (is_digit(lock_state) && new_val && code_match)
      |=> lock_state == ($past(lock_state) << 1));

  a_r4_wrong_entry: assert property (@(posedge clk) disable iff (rst)
    (is_digit(lock_state) && new_val && !code_match) |=> lock_state == '0);

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (lock_state == '0 || lock_state == st_open()) |=> $stable(lock_state));

  a_r6_open_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(door_open) |-> $past(new_val && code_match));

  a_r7_no_match_idle: assert property (@(posedge clk) disable iff (rst)
    (lock_state == '0 || door_open) |-> !code_match);

  a_r8_load_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (|load_en && !new_val) |=> $stable(lock_state));
endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk(clk), .rst(rst), .new_val(new_val), .load_en(load_en),
  .lock_state(lock_state), .door_open(door_open), .code_match(code_match)
);

// File: tb/sim_combo_lock.sv
module sim_combo_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] value_in = '0;
  logic       new_val = 1'b0;
  logic [2:0] load_en = '0;
  logic [3:0] lock_state;
  logic       door_open;
  logic       code_match;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] code [3] = '{4'h9, 4'h4, 4'hC};

  combo_lock u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with given inputs; inputs driven at negedge, sampled 1ns after posedge
  task automatic cyc(input logic [3:0] v, input logic nv, input logic [2:0] ld, input logic r);
    @(negedge clk);
    value_in = v; new_val = nv; load_en = ld; rst = r;
    @(posedge clk); #1;
    new_val = 0; load_en = '0; rst = 0;
  endtask

  task automatic reset_and_load();
    cyc(4'h0, 0, 3'b000, 1);
    for (int i = 0; i < 3; i++) cyc(code[i], 0, 3'(1 << i), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 / R10: reset state and cleared registers
    cyc(4'h0, 0, 3'b000, 1);
    chk("R1 state", lock_state, 4'b0001);
    chk("R1 door", door_open, 0);
    @(negedge clk); value_in = 4'h0; #1;
    chk("R10 cleared code", code_match, 1);

    // R8: loads do not move state and take effect
    for (int i = 0; i < 3; i++) begin
      cyc(code[i], 0, 3'(1 << i), 0);
      chk("R8 state kept", lock_state, 4'b0001);
    end
    @(negedge clk); value_in = code[0]; #1;
    chk("R8 loaded code1", code_match, 1);

    // R2: idle cycles hold
    for (int k = 0; k < 4; k++) begin
      cyc(4'(k), 0, 3'b000, 0);
      chk("R2 hold", lock_state, 4'b0001);
    end

    // exhaustive: every position, every value
    for (int pos = 0; pos < 3; pos++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] exp_st;
        reset_and_load();
        for (int p = 0; p < pos; p++) cyc(code[p], 1, 3'b000, 0);
        chk("R6 select", lock_state, 4'(1 << pos));
        @(negedge clk); value_in = 4'(v); #1;
        chk("R7 match", code_match, (4'(v) == code[pos]));
        cyc(4'(v), 1, 3'b000, 0);
        exp_st = (4'(v) == code[pos]) ? 4'(1 << (pos + 1)) : 4'b0000;
        chk(exp_st == 0 ? "R4 error" : "R3 advance", lock_state, exp_st);
        chk("R6 door", door_open, exp_st == 4'b1000);
        if (exp_st == 0) begin
          cyc(code[pos], 1, 3'b000, 0);
          chk("R5 error sticky", lock_state, 4'b0000);
          @(negedge clk); value_in = code[0]; #1;
          chk("R7 error no match", code_match, 0);
        end
      end
    end

    // open state sticky, no match
    reset_and_load();
    for (int p = 0; p < 3; p++) cyc(code[p], 1, 3'b000, 0);
    chk("R3 open", lock_state, 4'b1000);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); value_in = 4'(v); #1;
      chk("R7 open no match", code_match, 0);
      cyc(4'(v), 1, 3'b000, 0);
      chk("R5 open sticky", lock_state, 4'b1000);
      chk("R6 door open", door_open, 1);
    end
    cyc(4'h0, 0, 3'b000, 1);
    chk("R1 reset from open", lock_state, 4'b0001);

    // R9: load of compared register on strobe edge uses old contents
    reset_and_load();
    cyc(4'h5, 1, 3'b001, 0);
    chk("R9 old contents compared", lock_state, 4'b0000);
    // R9: load next register on matching strobe, next entry uses new word
    reset_and_load();
    cyc(code[0], 1, 3'b010, 0);
    chk("R9 advance with load", lock_state, 4'b0010);
    cyc(code[0], 1, 3'b000, 0);
    chk("R9 new word used", lock_state, 4'b0100);

    // R10: reset clears registers after loading
    cyc(4'h0, 0, 3'b000, 1);
    @(negedge clk); value_in = code[0]; #1;
    chk("R10 code cleared", code_match, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule